// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register Bank

This block gathers up to 96 level-sensitive peripheral interrupt lines, in groups of 32, and presents them to a processor through a small 32-bit register port. Each group has a read-only view of its raw lines, an enable mask, a routing register that sends each line to the normal interrupt (IRQ) or the fast interrupt (FIQ), and two filtered views showing which enabled lines are pending on each path. The IRQ and FIQ outputs are the OR of those filtered views. A wake output asks the processor to leave idle, either on any raw line or only on enabled lines, as a control bit selects.

Software ranks the sources through a table of priority slots, one per source position. Each slot names a source and carries a valid flag. A registered highest-priority word reports, for both IRQ and FIQ, the source named by the lowest-numbered valid slot whose source is pending on that path, so an interrupt handler reads one word to learn which source to serve.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Raw line status reads at word offset +0x000 of each group (group bases 0x000, 0x09C, 0x130, bit n of group g is source 32g+n); it follows the inputs and writes to it have no effect. Accesses with byte address bits [1:0] non-zero read 0 and write nothing.
- R2: The enable mask sits at group offset +0x004; a 1 enables a source. The IRQ-pending view at +0x010 equals raw AND mask AND NOT routing.
- R3: The routing register sits at group offset +0x008; 0 sends a source to IRQ, 1 to FIQ. The FIQ-pending view at +0x00C equals raw AND mask AND routing.
- R4: `irq_o` is 1 exactly when some IRQ-pending view bit is 1; `fiq_o` likewise for the FIQ-pending views.
- R5: Control at 0x014, bit 0: when 1, `wake_o` is the OR of raw AND mask over all sources; when 0, `wake_o` is the OR of all raw lines. Other bits read 0.
- R6: Priority slot i is the word at 0x01C+4i for i<32, 0x0B0+4(i-32) for 32≤i<64 and 0x144+4(i-64) above; bits 6:0 hold a source number, bit 31 the valid flag, all other bits read 0.
- R7: The highest-priority word at 0x018 has bit 31 set when some valid slot names a source in an IRQ-pending view, and bits 30:16 hold the source named by the lowest such slot; otherwise bits 31:16 are 0.
- R8: Bits 15:0 of the same word report the FIQ winner in the same way: bit 15 valid, bits 14:0 the source.
- R9: A slot whose valid bit is 0, or whose source number is 96 or above, never wins.
- R10: The highest-priority word reflects inputs and registers as they were one clock earlier.
- R11: After reset, mask, routing, control, every slot and the highest-priority word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Level-sensitive interrupt lines |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 9 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle-exit wake request |

## Verification
The hardest situation to reach is a winner decided by slot order rather than by source number, across groups and paths at once: a low slot naming a high source, a later slot naming a low source, an invalidated slot, an out-of-range source name and a FIQ-routed source all competing. The stimulus programs slots in groups 0, 1 and 2 so that the winning slot moves from slot 0 to slot 1 to slot 32 to slot 64, flipping routing and masks between reads. The one-cycle lag is caught by reading the priority word on the same half-cycle a line changes, before the next edge.

// File: rtl/picr_pkg.sv
// Package: shared address-map helpers for the prioritized interrupt controller.
// Assumes at most three groups of 32 sources; word addresses are byte/4.
package picr_pkg;

    localparam int GRP_W = 32;

    // Word index of a group's first register.
    function automatic int grp_base_w(input int g);
        return (g == 0) ? 0 : ('h27 + (g - 1) * 'h25);
    endfunction

    // Word index of a group's first priority slot.
    function automatic int slot_base_w(input int g);
        return (g == 0) ? 7 : (grp_base_w(g) + 5);
    endfunction

    // Register word offsets inside a group (control/winner only in group 0).
    localparam int OFS_RAW   = 0;
    localparam int OFS_MASK  = 1;
    localparam int OFS_ROUTE = 2;
    localparam int OFS_FIQV  = 3;
    localparam int OFS_IRQV  = 4;
    localparam int OFS_CTRL  = 5;
    localparam int OFS_WIN   = 6;

endpackage

// File: rtl/picr_group.sv
// Module: one group of sources: enable mask, routing register and the two
// filtered pending views. Assumes write strobes are already address-decoded.
module picr_group #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    input  logic             wr_mask_i,
    input  logic             wr_route_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] route_o,
    output logic [WIDTH-1:0] irq_view_o,
    output logic [WIDTH-1:0] fiq_view_o
);

    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] route_q;

    // Holds the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (wr_mask_i) mask_q <= wdata_i;
    end

    // Holds the IRQ/FIQ routing bits.
    always_ff @(posedge clk) begin
        if (!rst_n)          route_q <= '0;
        else if (wr_route_i) route_q <= wdata_i;
    end

    // Filters raw lines into the per-path pending views.
    always_comb begin
        irq_view_o = raw_i & mask_q & ~route_q;
        fiq_view_o = raw_i & mask_q & route_q;
    end

    assign mask_o  = mask_q;
    assign route_o = route_q;

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i |=> (mask_o == $past(wdata_i)));

    // R3
    path_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_view_o & fiq_view_o) == '0);

endmodule

// File: rtl/picr_slots.sv
// Module: priority slot table, one slot per source position, each a source
// number plus a valid flag. Assumes slot index is already decoded.
module picr_slots #(
    parameter int NUM_SRC = 96,
    parameter int SRC_W   = 7,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we_i,
    input  logic [IDX_W-1:0]                widx_i,
    input  logic                            wvld_i,
    input  logic [SRC_W-1:0]                wsrc_i,
    input  logic [IDX_W-1:0]                ridx_i,
    output logic [31:0]                     rdata_o,
    output logic [NUM_SRC-1:0]              vld_o,
    output logic [NUM_SRC-1:0][SRC_W-1:0]   src_o
);

    logic [NUM_SRC-1:0]            vld_q;
    logic [NUM_SRC-1:0][SRC_W-1:0] src_q;

    // Stores each slot on its addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            src_q <= '0;
        end else if (we_i) begin
            vld_q[widx_i] <= wvld_i;
            src_q[widx_i] <= wsrc_i;
        end
    end

    // Formats the addressed slot for readback.
    always_comb begin
        rdata_o              = '0;
        rdata_o[31]          = vld_q[ridx_i];
        rdata_o[SRC_W-1:0]   = src_q[ridx_i];
    end

    assign vld_o = vld_q;
    assign src_o = src_q;

    // R6
    slot_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (vld_o[$past(widx_i)] == $past(wvld_i)));

endmodule

// File: rtl/picr_resolve.sv
// Module: scans slots from 0 upward and registers the first valid slot whose
// source is pending on the IRQ path, and likewise on the FIQ path.
// Assumes source numbers at or above NUM_SRC name nothing.
module picr_resolve #(
    parameter int NUM_SRC = 96,
    parameter int SRC_W   = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            vld_i,
    input  logic [NUM_SRC-1:0][SRC_W-1:0] src_i,
    input  logic [NUM_SRC-1:0]            irq_view_i,
    input  logic [NUM_SRC-1:0]            fiq_view_i,
    output logic [31:0]                   win_o
);

    localparam int PAD = 1 << SRC_W;

    logic [PAD-1:0]   irq_pad, fiq_pad;
    logic             irq_hit, fiq_hit;
    logic [SRC_W-1:0] irq_win, fiq_win;
    logic             irq_vld_q, fiq_vld_q;
    logic [SRC_W-1:0] irq_src_q, fiq_src_q;

    // Widens the views so any slot source number indexes safely.
    always_comb begin
        irq_pad = PAD'(irq_view_i);
        fiq_pad = PAD'(fiq_view_i);
    end

    // Finds the lowest-numbered qualifying slot on each path.
    always_comb begin
        irq_hit = 1'b0;
        fiq_hit = 1'b0;
        irq_win = '0;
        fiq_win = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (vld_i[s] && irq_pad[src_i[s]]) begin
                irq_hit = 1'b1;
                irq_win = src_i[s];
            end
            if (vld_i[s] && fiq_pad[src_i[s]]) begin
                fiq_hit = 1'b1;
                fiq_win = src_i[s];
            end
        end
    end

    // Registers both winners for a shallow read path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_vld_q <= 1'b0;
            fiq_vld_q <= 1'b0;
            irq_src_q <= '0;
            fiq_src_q <= '0;
        end else begin
            irq_vld_q <= irq_hit;
            fiq_vld_q <= fiq_hit;
            irq_src_q <= irq_hit ? irq_win : '0;
            fiq_src_q <= fiq_hit ? fiq_win : '0;
        end
    end

    // Packs both winners into the reported word.
    always_comb begin
        win_o          = '0;
        win_o[31]      = irq_vld_q;
        win_o[15]      = fiq_vld_q;
        win_o[16 +: SRC_W] = irq_src_q;
        win_o[0 +: SRC_W]  = fiq_src_q;
    end

    // R7
    irq_win_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_o[31] |-> $past(|irq_view_i));

    // R8
    fiq_win_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_o[15] |-> $past(|fiq_view_i));

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the prioritized interrupt controller. Decodes the register
// port, holds the wake-control bit, instantiates the groups, slot table and
// resolver. Assumes NUM_GRP is 1 to 3; group 1 and 2 carry only five
// registers because their slot regions start right after them.
module prio_irq_ctrl
    import picr_pkg::*;
#(
    parameter int NUM_GRP = 3,
    parameter int ADDR_W  = 9,
    localparam int NUM_SRC = NUM_GRP * GRP_W,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);

    logic [NUM_GRP-1:0]            wr_mask, wr_route;
    logic [NUM_GRP-1:0][GRP_W-1:0] mask_v, route_v, irq_v, fiq_v;
    logic [NUM_SRC-1:0]            mask_all, irq_all, fiq_all;
    logic                          ctrl_q;
    logic                          wr_ctrl;
    logic                          slot_hit;
    logic [IDX_W-1:0]              slot_idx;
    logic [31:0]                   slot_rdata, win_word;
    logic [NUM_SRC-1:0]            slot_vld;
    logic [NUM_SRC-1:0][SRC_W-1:0] slot_src;
    logic                          aligned;
    int                            waddr;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign waddr   = int'(addr_i[ADDR_W-1:2]);

    // Decodes the word address into write strobes and the slot index.
    always_comb begin
        wr_mask  = '0;
        wr_route = '0;
        wr_ctrl  = 1'b0;
        slot_hit = 1'b0;
        slot_idx = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (waddr == grp_base_w(g) + OFS_MASK)  wr_mask[g]  = wr_en_i && aligned;
            if (waddr == grp_base_w(g) + OFS_ROUTE) wr_route[g] = wr_en_i && aligned;
            if (waddr >= slot_base_w(g) && waddr < slot_base_w(g) + GRP_W) begin
                slot_hit = aligned;
                slot_idx = IDX_W'(g * GRP_W + waddr - slot_base_w(g));
            end
        end
        if (waddr == OFS_CTRL) wr_ctrl = wr_en_i && aligned;
    end

    // Holds the wake-source select bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= 1'b0;
        else if (wr_ctrl) ctrl_q <= wdata_i[0];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        picr_group #(.WIDTH(GRP_W)) u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_i      (src_i[g*GRP_W +: GRP_W]),
            .wr_mask_i  (wr_mask[g]),
            .wr_route_i (wr_route[g]),
            .wdata_i    (wdata_i),
            .mask_o     (mask_v[g]),
            .route_o    (route_v[g]),
            .irq_view_o (irq_v[g]),
            .fiq_view_o (fiq_v[g])
        );
    end

    assign mask_all = mask_v;
    assign irq_all  = irq_v;
    assign fiq_all  = fiq_v;

    picr_slots #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i && slot_hit),
        .widx_i  (slot_idx),
        .wvld_i  (wdata_i[31]),
        .wsrc_i  (wdata_i[SRC_W-1:0]),
        .ridx_i  (slot_idx),
        .rdata_o (slot_rdata),
        .vld_o   (slot_vld),
        .src_o   (slot_src)
    );

    picr_resolve #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_resolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (slot_vld),
        .src_i      (slot_src),
        .irq_view_i (irq_all),
        .fiq_view_i (fiq_all),
        .win_o      (win_word)
    );

    // Drives the request and wake pins.
    always_comb begin
        irq_o  = |irq_all;
        fiq_o  = |fiq_all;
        wake_o = ctrl_q ? |(src_i & mask_all) : |src_i;
    end

    // Selects read data for the addressed register.
    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (waddr == grp_base_w(g) + OFS_RAW)   rdata_o = src_i[g*GRP_W +: GRP_W];
                if (waddr == grp_base_w(g) + OFS_MASK)  rdata_o = mask_v[g];
                if (waddr == grp_base_w(g) + OFS_ROUTE) rdata_o = route_v[g];
                if (waddr == grp_base_w(g) + OFS_FIQV)  rdata_o = fiq_v[g];
                if (waddr == grp_base_w(g) + OFS_IRQV)  rdata_o = irq_v[g];
            end
            if (waddr == OFS_CTRL) rdata_o = {31'd0, ctrl_q};
            if (waddr == OFS_WIN)  rdata_o = win_word;
            if (slot_hit)          rdata_o = slot_rdata;
        end
    end

    // R10
    no_irq_no_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |=> !win_word[31]);

    // R5
    wake_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && ctrl_q) |-> (irq_o || fiq_o));

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic        wr_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq, wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit          pins;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
    );

    // Monitor: pops expected items and compares just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.pins ? {29'd0, irq, fiq, wake} : rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [8:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a;
        sb_q.push_back('{1'b0, e, tag});
    endtask

    task automatic chk_pins(input logic [2:0] e, input string tag);
        @(negedge clk);
        sb_q.push_back('{1'b1, {29'd0, e}, tag});
    endtask

    task automatic set_src(input logic [95:0] v);
        @(negedge clk);
        src = v;
    endtask

    // Changes the lines and reads the winner before the next edge.
    task automatic set_src_chk_old(input logic [95:0] v, input logic [31:0] e, input string tag);
        @(negedge clk);
        src = v;
        addr = 9'h018;
        sb_q.push_back('{1'b0, e, tag});
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk_rd(9'h004, 32'h0, "R11 mask");
        chk_rd(9'h008, 32'h0, "R11 routing");
        chk_rd(9'h014, 32'h0, "R11 control");
        chk_rd(9'h018, 32'h0, "R11 winner");
        chk_rd(9'h01C, 32'h0, "R11 slot0");
        chk_pins(3'b000, "R11 pins");

        // R1 raw lines, read-only, group addressing
        set_src((96'd1 << 5) | (96'd1 << 40));
        chk_rd(9'h000, 32'h0000_0020, "R1 raw group0");
        chk_rd(9'h09C, 32'h0000_0100, "R1 raw group1");
        wr(9'h000, 32'hFFFF_FFFF);
        chk_rd(9'h000, 32'h0000_0020, "R1 raw write ignored");
        chk_rd(9'h001, 32'h0, "R1 misaligned read");

        // R5 wake select
        chk_pins(3'b001, "R5 wake on raw");
        wr(9'h014, 32'h1);
        chk_rd(9'h014, 32'h1, "R5 control readback");
        chk_pins(3'b000, "R5 wake needs enable");

        // R2 / R4 mask and IRQ view
        wr(9'h004, 32'h20);
        chk_rd(9'h010, 32'h20, "R2 irq view");
        chk_pins(3'b101, "R4 irq pin");

        // R3 routing to FIQ
        wr(9'h008, 32'h20);
        chk_rd(9'h00C, 32'h20, "R3 fiq view");
        chk_rd(9'h010, 32'h0, "R3 irq view cleared");
        chk_pins(3'b011, "R4 fiq pin");

        // R6 / R7 slot ordering
        wr(9'h008, 32'h0);
        wr(9'h0A0, 32'h100);
        wr(9'h01C, 32'h8000_0028);
        wr(9'h020, 32'h8000_0005);
        chk_rd(9'h018, 32'h8028_0000, "R7 slot0 wins");
        chk_rd(9'h01C, 32'h8000_0028, "R6 slot0 readback");

        // R9 invalid slot skipped
        wr(9'h01C, 32'h0000_0028);
        chk_rd(9'h018, 32'h8005_0000, "R9 invalid slot skipped");

        // R8 FIQ winner
        wr(9'h008, 32'h20);
        chk_rd(9'h018, 32'h0000_8005, "R8 fiq winner");

        // R6 / R9 unused bits and out-of-range source
        wr(9'h028, 32'hFFFF_FFFF);
        chk_rd(9'h028, 32'h8000_007F, "R6 slot field masking");
        chk_rd(9'h018, 32'h0000_8005, "R9 out-of-range source");

        // R6 / R7 group 2 and group 1 slot regions
        set_src((96'd1 << 5) | (96'd1 << 40) | (96'd1 << 70));
        wr(9'h134, 32'h40);
        wr(9'h144, 32'h8000_0046);
        chk_rd(9'h144, 32'h8000_0046, "R6 slot64 readback");
        chk_rd(9'h018, 32'h8046_8005, "R7 slot64 wins");
        wr(9'h0B0, 32'h8000_0028);
        chk_rd(9'h0B0, 32'h8000_0028, "R6 slot32 readback");
        chk_rd(9'h018, 32'h8028_8005, "R7 slot32 beats slot64");

        // R10 one-cycle lag
        set_src_chk_old((96'd1 << 5) | (96'd1 << 70), 32'h8028_8005, "R10 old value");
        chk_rd(9'h018, 32'h8046_8005, "R10 new value");

        // R2 / R5 disabling group 2
        wr(9'h134, 32'h0);
        chk_rd(9'h018, 32'h0000_8005, "R2 mask clears winner");
        chk_pins(3'b011, "R5 wake from enabled fiq");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule